// File: doc/BRIEF.md
# One-hot multiplexer tree

This block selects one of N data words by a select vector that is normally one-hot. It has no storage. It is built as a balanced binary tree of two-input multiplexers. At every node, the steering term is the OR of the select bits that belong to the node's lower half. When that term is set, the lower half's result goes to the output. Otherwise the upper half's result goes to the output.

An optional default word can be enabled by a parameter. When enabled, the default word joins the tree as one more leaf, placed above the highest data word. Its select term is the NOR of all select bits. The block is intended as a drop-in parallel-case selector inside larger datapaths. It can be instantiated for any word count, including a single word and word counts that are not powers of two.

Top module: `onehot_mux_tree`

## Requirements
- R1: Data word i occupies bits [i*W +: W] of the packed data input. Select bit i (bit 0 the least significant) chooses word i.
- R2: When exactly one select bit i is set, the output equals data word i.
- R3: With the default enabled (HAS_DFLT=1) and all select bits clear, the output equals the default word.
- R4: With the default enabled, the default word has no effect on the output while any select bit is set.
- R5: With the default disabled (HAS_DFLT=0) and all select bits clear, the output equals the highest-index data word, word N-1.
- R6: When several select bits are set, the output equals the data word with the lowest set index.
- R7: The output is a function of the present inputs only. It settles within the same time step as an input change, with no clock involved.
- R8: For N=1 with no default, the single word passes through whatever the select bit is. For N=1 with a default, select 1 gives the word and select 0 gives the default.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sel_i | input | N | Select vector, bit i picks word i |
| data_i | input | N*W | Data words packed end to end, word 0 in the low bits |
| dflt_i | input | W | Default word, used only when HAS_DFLT=1 |
| y_o | output | W | Selected word |

## Verification
The assertions assume that the inputs hold steady 2-state values whenever the combinational logic is evaluated. They do not assume that the select vector is one-hot. Instead, they cover the one-hot, all-clear and multi-hot cases separately, so every select pattern is legal stimulus. The bench drives every input away from the clock edges. It changes all inputs at once and then waits a short delay before sampling. This means no check sees a half-updated input set. The bench uses several instances (N of 1, 5, 7 and 8, with and without a default) so that both odd and even splits of the tree are exercised.

// File: rtl/omt_pkg.sv
package omt_pkg;
    // Number of select bits handed to the lower half of a node.
    function automatic int lo_count(input int n);
        return n / 2;
    endfunction

    // Number of select bits handed to the upper half of a node.
    function automatic int hi_count(input int n);
        return n - (n / 2);
    endfunction

    // Port width guard, so that zero-sized groups still elaborate.
    function automatic int at_least_one(input int n);
        return (n < 1) ? 1 : n;
    endfunction
endpackage

// File: rtl/omt_or_reduce.sv
module omt_or_reduce #(
    parameter int N = 2
) (
    input  logic [omt_pkg::at_least_one(N)-1:0] bits_i,
    output logic                                any_o
);
    generate
        if (N == 0) begin : g_empty
            logic unused_bits;
            assign unused_bits = ^bits_i;
            assign any_o = 1'b0;
        end else if (N == 1) begin : g_single
            assign any_o = bits_i[0];
        end else if (N == 2) begin : g_pair
            assign any_o = bits_i[0] | bits_i[1];
        end else begin : g_wide
            assign any_o = |bits_i;
        end
    endgenerate
endmodule

// File: rtl/omt_node.sv
module omt_node #(
    parameter int N = 4,
    parameter int W = 8
) (
    input  logic [N-1:0]   sel_i,
    input  logic [N*W-1:0] data_i,
    output logic [W-1:0]   y_o
);
    localparam int NLO = omt_pkg::lo_count(N);
    localparam int NHI = omt_pkg::hi_count(N);

    generate
        if (N == 1) begin : g_leaf
            // A leaf passes its word straight through; its select bit only
            // feeds OR terms higher up.
            logic unused_sel;
            assign unused_sel = sel_i[0];
            assign y_o = data_i;
        end else begin : g_split
            logic [W-1:0] lo_y_d;
            logic [W-1:0] hi_y_d;
            logic         lo_any_d;

            omt_node #(.N(NLO), .W(W)) u_lo (
                .sel_i  (sel_i[NLO-1:0]),
                .data_i (data_i[NLO*W-1:0]),
                .y_o    (lo_y_d)
            );

            omt_node #(.N(NHI), .W(W)) u_hi (
                .sel_i  (sel_i[N-1:NLO]),
                .data_i (data_i[N*W-1:NLO*W]),
                .y_o    (hi_y_d)
            );

            omt_or_reduce #(.N(NLO)) u_or (
                .bits_i (sel_i[NLO-1:0]),
                .any_o  (lo_any_d)
            );

            always_comb begin
                y_o = lo_any_d ? lo_y_d : hi_y_d;
            end

            // R5: with no select bit in this subtree, the highest leaf wins.
            always_comb begin
                if (sel_i == '0) begin
                    assert_node_idle_top_R5: assert (y_o == data_i[(N-1)*W +: W])
                        else $error("node idle output mismatch");
                end
            end
        end
    endgenerate
endmodule

// File: rtl/onehot_mux_tree.sv
module onehot_mux_tree #(
    parameter int N        = 5,
    parameter int W        = 8,
    parameter bit HAS_DFLT = 1'b1
) (
    input  logic [N-1:0]   sel_i,
    input  logic [N*W-1:0] data_i,
    input  logic [W-1:0]   dflt_i,
    output logic [W-1:0]   y_o
);
    localparam int LEAVES = HAS_DFLT ? N + 1 : N;

    logic [LEAVES-1:0]   leaf_sel_d;
    logic [LEAVES*W-1:0] leaf_data_d;

    generate
        if (HAS_DFLT) begin : g_dflt
            // Default word becomes the top leaf, chosen by the NOR of all selects.
            assign leaf_sel_d  = {~(|sel_i), sel_i};
            assign leaf_data_d = {dflt_i, data_i};
        end else begin : g_plain
            logic unused_dflt;
            assign unused_dflt = ^dflt_i;
            assign leaf_sel_d  = sel_i;
            assign leaf_data_d = data_i;
        end
    endgenerate

    omt_node #(.N(LEAVES), .W(W)) u_root (
        .sel_i  (leaf_sel_d),
        .data_i (leaf_data_d),
        .y_o    (y_o)
    );

    // Port-level checks on the selection rules.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            if (sel_i == (N'(1) << i)) begin
                assert_onehot_pick_R2: assert (y_o == data_i[i*W +: W])
                    else $error("one-hot select %0d mismatch", i);
            end
        end
        if (sel_i == '0) begin
            if (HAS_DFLT) begin
                assert_idle_default_R3: assert (y_o == dflt_i)
                    else $error("idle select did not give default");
            end else begin
                assert_idle_last_R5: assert (y_o == data_i[(N-1)*W +: W])
                    else $error("idle select did not give last word");
            end
        end
    end

    // R6: lowest set index wins when several select bits are set.
    always_comb begin
        int low_idx;
        low_idx = -1;
        for (int i = N - 1; i >= 0; i--) begin
            if (sel_i[i]) low_idx = i;
        end
        if ($countones(sel_i) > 1) begin
            assert_lowest_wins_R6: assert (y_o == data_i[low_idx*W +: W])
                else $error("multi-hot priority mismatch");
        end
    end
endmodule

// File: tb/sim_onehot_mux_tree.sv
module sim_onehot_mux_tree;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [7:0]  sel_all;
    logic [63:0] data_all;
    logic [7:0]  dflt;

    logic [W-1:0] y0, y1, y2, y3, y4;

    // N=5 with default
    onehot_mux_tree #(.N(5), .W(W), .HAS_DFLT(1'b1)) u0 (
        .sel_i(sel_all[4:0]), .data_i(data_all[39:0]), .dflt_i(dflt), .y_o(y0));
    // N=1 without default
    onehot_mux_tree #(.N(1), .W(W), .HAS_DFLT(1'b0)) u1 (
        .sel_i(sel_all[0:0]), .data_i(data_all[7:0]), .dflt_i(dflt), .y_o(y1));
    // N=1 with default
    onehot_mux_tree #(.N(1), .W(W), .HAS_DFLT(1'b1)) u2 (
        .sel_i(sel_all[0:0]), .data_i(data_all[7:0]), .dflt_i(dflt), .y_o(y2));
    // N=7 without default
    onehot_mux_tree #(.N(7), .W(W), .HAS_DFLT(1'b0)) u3 (
        .sel_i(sel_all[6:0]), .data_i(data_all[55:0]), .dflt_i(dflt), .y_o(y3));
    // N=8 with default
    onehot_mux_tree #(.N(8), .W(W), .HAS_DFLT(1'b1)) u4 (
        .sel_i(sel_all[7:0]), .data_i(data_all[63:0]), .dflt_i(dflt), .y_o(y4));

    // Reference from the requirements: lowest set index, else default or last word.
    function automatic logic [7:0] ref_pick(input int n, input bit hasd);
        for (int i = 0; i < n; i++) begin
            if (sel_all[i]) return data_all[i*8 +: 8];
        end
        if (hasd) return dflt;
        return data_all[(n-1)*8 +: 8];
    endfunction

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic apply_and_check(input string req,
                                   input logic [7:0] s, input logic [63:0] d,
                                   input logic [7:0] f);
        @(negedge clk);
        sel_all = s; data_all = d; dflt = f;
        #2;
        check(req, "u0 N5 dflt", y0, ref_pick(5, 1'b1));
        check(req, "u1 N1",      y1, ref_pick(1, 1'b0));
        check(req, "u2 N1 dflt", y2, ref_pick(1, 1'b1));
        check(req, "u3 N7",      y3, ref_pick(7, 1'b0));
        check(req, "u4 N8 dflt", y4, ref_pick(8, 1'b1));
    endtask

    localparam logic [63:0] PAT_A = 64'h8877_6655_4433_2211;
    localparam logic [63:0] PAT_B = 64'h0f1e_2d3c_4b5a_6978;

    task automatic test_zero_state;
        // All inputs zero after reset: every output is zero.
        @(negedge clk);
        #2;
        check("R1", "zero state u0", y0, 8'h00);
        check("R1", "zero state u4", y4, 8'h00);
    endtask

    task automatic test_onehot;
        // R1 R2: each word reached by its own bit.
        for (int i = 0; i < 8; i++) begin
            apply_and_check("R2", 8'(1 << i), PAT_A, 8'hee);
            check("R1", "word position u4", y4, PAT_A[i*8 +: 8]);
        end
    endtask

    task automatic test_idle;
        apply_and_check("R3", 8'h00, PAT_B, 8'hc3);
        check("R3", "u4 idle default", y4, 8'hc3);
        check("R5", "u3 idle last word", y3, PAT_B[6*8 +: 8]);
    endtask

    task automatic test_default_ignored;
        // R4: changing the default with a select set leaves the output alone.
        apply_and_check("R4", 8'h04, PAT_A, 8'h00);
        apply_and_check("R4", 8'h04, PAT_A, 8'hff);
        check("R4", "u0 default ignored", y0, PAT_A[2*8 +: 8]);
    endtask

    task automatic test_multihot;
        logic [7:0] s;
        logic [63:0] d;
        apply_and_check("R6", 8'b1010_0110, PAT_A, 8'h5a);
        check("R6", "u4 lowest of 1,2,5,7", y4, PAT_A[1*8 +: 8]);
        for (int k = 0; k < 40; k++) begin
            s = 8'($urandom);
            d = {$urandom, $urandom};
            apply_and_check("R6", s, d, 8'($urandom));
        end
    endtask

    task automatic test_single_word;
        apply_and_check("R8", 8'h00, PAT_B, 8'h99);
        check("R8", "u1 ignores select 0", y1, PAT_B[7:0]);
        check("R8", "u2 default at select 0", y2, 8'h99);
        apply_and_check("R8", 8'h01, PAT_B, 8'h99);
        check("R8", "u2 word at select 1", y2, PAT_B[7:0]);
    endtask

    task automatic test_live;
        // R7: output follows a change made between clock edges.
        @(posedge clk);
        #3;
        sel_all = 8'h08; data_all = PAT_B; dflt = 8'h11;
        #1;
        check("R7", "u0 live update", y0, PAT_B[3*8 +: 8]);
        data_all[3*8 +: 8] = 8'h3c;
        #1;
        check("R7", "u0 live data", y0, 8'h3c);
    endtask

    initial begin
        sel_all = '0; data_all = '0; dflt = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        test_zero_state();
        test_onehot();
        test_idle();
        test_default_ignored();
        test_multihot();
        test_single_word();
        test_live();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule